// File: doc/BRIEF.md
# Two-Source Word DMA Arbiter

This block sits between two timer event sources, a compare channel and a capture channel, and a DMA engine that moves one byte per transfer. Each source asks for a 16-bit word. The arbiter carries out that word as two byte grants in a row, low byte first and then high byte. A request is stored as pending. It stays pending until its word completes, so a short pulse on a request line is enough.

The arbiter presents one effective priority level to the DMA engine. This is normally the programmed level. While the high byte of a word is in service, it is forced to the top level, which is zero (a smaller value means a higher priority). As a result, the second half of a word is never delayed. The other timer source cannot get in between the two halves. A new word starts only when the external bus-available input is high. When both sources are pending, the compare source wins.

Top module: `word_dma_arb`

## Requirements
- R1: While `rst` is high at a rising edge, the block returns to idle: `byte_grant` and `word_done` low, no source locked, no requests pending. `eff_prio` equals `prog_prio`.
- R2: A word starts only when a request is pending and `bus_avail` is high at a rising edge. `byte_grant` rises one edge after the edge that captured the request. It stays low while `bus_avail` is low.
- R3: When both sources are pending in idle, the compare source is served first. The capture request stays pending and is served next. `chan_id` is 0 for compare and 1 for capture.
- R4: A word is two byte grants on the same `chan_id`: first with `byte_hi` = 0, then with `byte_hi` = 1. Each grant holds, with `chan_id` and `byte_hi` unchanged, until `byte_ack` is seen high at a rising edge.
- R5: While the high byte is granted, `eff_prio` is 3'b000. At all other times, it equals `prog_prio` as sampled at the previous rising edge.
- R6: A request from the other source that arrives during a word is not granted until that word has finished.
- R7: `word_done` is a one-cycle pulse in the cycle after the high byte is acknowledged. It clears that source's pending request. A source with no new request receives no further grant.
- R8: The high byte is granted without waiting for `bus_avail`.
- R9: Repeated requests from one source before its word completes merge into a single word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmp_req | input | 1 | Word request from the compare source |
| cap_req | input | 1 | Word request from the capture source |
| prog_prio | input | PRIO_W | Programmed priority level, 0 is highest |
| bus_avail | input | 1 | Bus may accept the first byte of a new word |
| byte_ack | input | 1 | Bus side has completed the granted byte |
| byte_grant | output | 1 | A byte transfer is granted |
| chan_id | output | 1 | Served source: 0 compare, 1 capture |
| byte_hi | output | 1 | 0 low byte, 1 high byte |
| word_done | output | 1 | One-cycle pulse when a word completes |
| eff_prio | output | PRIO_W | Effective priority presented to the DMA engine |

## Verification
The bench builds the block with the default PRIO_W of 3. At that width, every programmed level from 0 to 7 is reachable. A nonzero level therefore makes the forced drop to zero on the high byte visible. The source count is fixed at two. Random request, bus-available and acknowledge patterns therefore reach both orderings of simultaneous requests, requests that land in either byte of a running word, and requests that coincide with a word's completion. Directed cases pin down the held-off start, the high byte issued with the bus unavailable, and the merging of repeated requests.

// File: rtl/dmaarb_pkg.sv
package dmaarb_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LO   = 2'd1,
    SEQ_HI   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/dmaarb_pend.sv
// Per-source pending latch: set by a request, cleared by completion of its word.
module dmaarb_pend #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] pend
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic pend_q;
    always_ff @(posedge clk) begin
      if (rst)          pend_q <= 1'b0;
      else if (req[i])  pend_q <= 1'b1;
      else if (clr[i])  pend_q <= 1'b0;
    end
    assign pend[i] = pend_q;

    // R7: completion without a fresh request leaves the source idle
    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !req[i]) |=> !pend[i]);
    // R9: a pending request is never lost before its completion
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (pend[i] && !clr[i]) |=> pend[i]);
  end
endmodule

// File: rtl/dmaarb_pick.sv
// Fixed-order selector: the lowest source index wins.
module dmaarb_pick #(
  parameter int NSRC = 2,
  parameter int IDW  = 1
) (
  input  logic [NSRC-1:0] pend,
  output logic            any,
  output logic [IDW-1:0]  idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        any = 1'b1;
        idx = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/dmaarb_seq.sv
// Word sequencer: locks one source for two byte grants.
module dmaarb_seq
  import dmaarb_pkg::*;
#(
  parameter int NSRC = 2,
  parameter int IDW  = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            any,
  input  logic [IDW-1:0]  idx,
  input  logic            bus_avail,
  input  logic            byte_ack,
  output logic            grant,
  output logic [IDW-1:0]  chan,
  output logic            hi,
  output logic            done,
  output logic            nxt_hi,
  output logic [NSRC-1:0] clr
);
  seq_state_e       st_q;
  logic [IDW-1:0]   chan_q;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SEQ_IDLE;
      chan_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        SEQ_IDLE: if (any && bus_avail) begin
          st_q   <= SEQ_LO;
          chan_q <= idx;
        end
        SEQ_LO: if (byte_ack) st_q <= SEQ_HI;
        SEQ_HI: if (byte_ack) begin
          st_q   <= SEQ_IDLE;
          done_q <= 1'b1;
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign grant  = (st_q != SEQ_IDLE);
  assign hi     = (st_q == SEQ_HI);
  assign chan   = chan_q;
  assign done   = done_q;
  assign nxt_hi = ((st_q == SEQ_LO) && byte_ack) || ((st_q == SEQ_HI) && !byte_ack);

  for (genvar i = 0; i < NSRC; i++) begin : g_clr
    assign clr[i] = (st_q == SEQ_HI) && byte_ack && (chan_q == IDW'(i));
  end

  // R2: a word only starts after the bus was available
  p_start_bus_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(grant) |-> $past(bus_avail));
  // R4: grant, source and byte index hold until acknowledged
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (grant && !byte_ack) |=> (grant && $stable(chan) && $stable(hi)));
  // R4: low byte is followed by high byte of the same source
  p_lo_hi_r4: assert property (@(posedge clk) disable iff (rst)
    (grant && !hi && byte_ack) |=> (grant && hi && $stable(chan)));
  // R6: after the high byte the arbiter passes through idle
  p_no_split_r6: assert property (@(posedge clk) disable iff (rst)
    (grant && hi && byte_ack) |=> (!grant && done));
  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/word_dma_arb.sv
module word_dma_arb #(
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_req,
  input  logic              cap_req,
  input  logic [PRIO_W-1:0] prog_prio,
  input  logic              bus_avail,
  input  logic              byte_ack,
  output logic              byte_grant,
  output logic              chan_id,
  output logic              byte_hi,
  output logic              word_done,
  output logic [PRIO_W-1:0] eff_prio
);
  localparam int NSRC = 2;
  localparam int IDW  = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [PRIO_W-1:0] TOP_LEVEL = '0;

  logic [NSRC-1:0]   req_v, clr_v, pend_v;
  logic              any;
  logic [IDW-1:0]    idx, chan;
  logic              nxt_hi;
  logic [PRIO_W-1:0] eff_q;

  assign req_v = {cap_req, cmp_req};

  dmaarb_pend #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst(rst), .req(req_v), .clr(clr_v), .pend(pend_v)
  );

  dmaarb_pick #(.NSRC(NSRC), .IDW(IDW)) u_pick (
    .pend(pend_v), .any(any), .idx(idx)
  );

  dmaarb_seq #(.NSRC(NSRC), .IDW(IDW)) u_seq (
    .clk(clk), .rst(rst), .any(any), .idx(idx),
    .bus_avail(bus_avail), .byte_ack(byte_ack),
    .grant(byte_grant), .chan(chan), .hi(byte_hi), .done(word_done),
    .nxt_hi(nxt_hi), .clr(clr_v)
  );

  always_ff @(posedge clk) begin
    if (rst)         eff_q <= prog_prio;
    else if (nxt_hi) eff_q <= TOP_LEVEL;
    else             eff_q <= prog_prio;
  end

  assign eff_prio = eff_q;
  assign chan_id  = chan[0];

  // R5: high byte always runs at the top level
  p_hi_prio_r5: assert property (@(posedge clk) disable iff (rst)
    (byte_grant && byte_hi) |-> (eff_prio == TOP_LEVEL));
  // R5: outside the high byte the programmed level is restored
  p_restore_r5: assert property (@(posedge clk) disable iff (rst)
    !(byte_grant && byte_hi) |-> (eff_prio == $past(prog_prio)));
  // R2: a fresh word needs a pending request
  p_need_req_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(byte_grant) |-> $past(pend_v != '0));
endmodule

// File: tb/word_dma_arb_test.sv
`timescale 1ns/1ps
module word_dma_arb_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst, cmp_req, cap_req, bus_avail, byte_ack;
  logic [2:0] prog_prio;
  logic       byte_grant, chan_id, byte_hi, word_done;
  logic [2:0] eff_prio;

  word_dma_arb #(.PRIO_W(3)) uut (
    .clk(clk), .rst(rst), .cmp_req(cmp_req), .cap_req(cap_req),
    .prog_prio(prog_prio), .bus_avail(bus_avail), .byte_ack(byte_ack),
    .byte_grant(byte_grant), .chan_id(chan_id), .byte_hi(byte_hi),
    .word_done(word_done), .eff_prio(eff_prio)
  );

  int n_cmp = 0, n_bad = 0;
  int wd0 = 0, wd1 = 0;
  bit finished = 0;

  // reference state
  int         m_st;
  logic       m_ch, m_done;
  logic [1:0] m_pend;
  logic [2:0] m_eff;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  function automatic logic exp_pick(input logic [1:0] p);
    return p[0] ? 1'b0 : 1'b1;   // compare (0) before capture (1)
  endfunction

  task automatic step(input logic [1:0] rq, input logic ba, input logic ack,
                      input logic [2:0] pr, input logic r);
    int ns;
    logic [1:0] clr;
    if (r) begin
      m_st = 0; m_ch = 0; m_pend = 0; m_done = 0; m_eff = pr;
      return;
    end
    clr = (m_st == 2 && ack) ? (m_ch ? 2'b10 : 2'b01) : 2'b00;
    ns = m_st;
    m_done = 0;
    case (m_st)
      0: if (m_pend != 0 && ba) begin ns = 1; m_ch = exp_pick(m_pend); end
      1: if (ack) ns = 2;
      2: if (ack) begin ns = 0; m_done = 1; end
      default: ns = 0;
    endcase
    m_pend = (m_pend & ~clr) | rq;
    m_eff  = (ns == 2) ? 3'd0 : pr;
    m_st   = ns;
  endtask

  task automatic compare();
    chk(byte_grant == (m_st != 0), "R2 grant", byte_grant, m_st != 0);
    chk(byte_hi == (m_st == 2), "R4 byte_hi", byte_hi, m_st == 2);
    if (m_st != 0) chk(chan_id == m_ch, "R3 chan_id", chan_id, m_ch);
    chk(word_done == m_done, "R7 word_done", word_done, m_done);
    chk(eff_prio == m_eff, "R5 eff_prio", eff_prio, m_eff);
    if (word_done) begin
      if (chan_id) wd1++; else wd0++;
    end
  endtask

  task automatic cyc(input logic [1:0] rq, input logic ba, input logic ack);
    cmp_req = rq[0]; cap_req = rq[1]; bus_avail = ba; byte_ack = ack;
    step(rq, ba, ack, prog_prio, rst);
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int base;
    rst = 1; prog_prio = 3'd5;
    cmp_req = 0; cap_req = 0; bus_avail = 0; byte_ack = 0;
    @(negedge clk);
    cyc(2'b11, 1, 1);
    cyc(2'b00, 1, 0);
    // R1: reset state
    chk(!byte_grant && !word_done, "R1 idle", byte_grant, 0);
    chk(eff_prio == 3'd5, "R1 eff_prio", eff_prio, 5);
    rst = 0;
    cyc(2'b00, 1, 0);
    chk(!byte_grant, "R1 nothing pending", byte_grant, 0);

    // R2: start held off while the bus is unavailable
    cyc(2'b01, 0, 0);
    for (int i = 0; i < 4; i++) begin
      cyc(2'b00, 0, 0);
      chk(!byte_grant, "R2 held off", byte_grant, 0);
    end
    cyc(2'b00, 1, 0);
    chk(byte_grant && !byte_hi && chan_id == 0, "R2 start", byte_grant, 1);
    cyc(2'b00, 0, 1);
    chk(byte_hi && eff_prio == 0, "R5 forced top level", eff_prio, 0);
    // R8: high byte proceeds with the bus unavailable
    cyc(2'b00, 0, 0);
    chk(byte_grant && byte_hi, "R8 high byte", byte_grant, 1);
    cyc(2'b00, 0, 1);
    chk(word_done && !byte_grant, "R7 done", word_done, 1);
    chk(eff_prio == 3'd5, "R5 restored", eff_prio, 5);
    cyc(2'b00, 1, 0);
    chk(!byte_grant && !word_done, "R7 no further grant", byte_grant, 0);

    // R3: simultaneous requests
    cyc(2'b11, 1, 0);
    cyc(2'b00, 1, 0);
    chk(byte_grant && chan_id == 0, "R3 compare first", chan_id, 0);
    cyc(2'b00, 1, 1);
    cyc(2'b00, 1, 1);
    cyc(2'b00, 1, 0);
    chk(byte_grant && chan_id == 1, "R3 capture next", chan_id, 1);
    cyc(2'b00, 1, 1);
    cyc(2'b00, 1, 1);

    // R6: capture request arrives between the two bytes
    prog_prio = 3'd2;
    cyc(2'b01, 1, 0);
    cyc(2'b00, 1, 0);
    cyc(2'b10, 1, 1);
    chk(byte_hi && chan_id == 0, "R6 word kept", chan_id, 0);
    cyc(2'b00, 1, 0);
    chk(byte_hi && chan_id == 0, "R6 still locked", chan_id, 0);
    cyc(2'b00, 1, 1);
    cyc(2'b00, 1, 0);
    chk(byte_grant && chan_id == 1, "R6 other served after", chan_id, 1);
    cyc(2'b00, 1, 1);
    cyc(2'b00, 1, 1);

    // R9: repeated requests merge
    base = wd0;
    cyc(2'b01, 0, 0);
    cyc(2'b01, 0, 0);
    cyc(2'b01, 0, 0);
    cyc(2'b00, 1, 0);
    cyc(2'b00, 1, 1);
    cyc(2'b00, 1, 1);
    for (int i = 0; i < 3; i++) cyc(2'b00, 1, 1);
    chk(wd0 - base == 1 && !byte_grant, "R9 one word", wd0 - base, 1);

    // random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] rq;
      rq[0] = ($urandom % 6) == 0;
      rq[1] = ($urandom % 6) == 0;
      if (($urandom % 16) == 0) prog_prio = 3'($urandom);
      cyc(rq, ($urandom % 4) != 0, ($urandom % 2) != 0);
    end
    for (int i = 0; i < 10; i++) cyc(2'b00, 1, 1);
    chk(!byte_grant, "R7 drained", byte_grant, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule